// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip request bus with valid/ready handshaking and an external asynchronous static RAM of 128K bytes. Each accepted request is a single byte read or a single byte write. The sequencer turns it into a pin sequence on the RAM side. That side has a 17-bit address, split data-out, data-in and driver-enable lines for the bidirectional byte bus, a select pair made of one active-low and one active-high chip enable, and active-low write and output strobes. Each phase is held for a whole number of clock cycles. That number is computed from the clock period and the nanosecond limits of the chosen speed grade.

Requests are served one at a time. A read places the address, selects the device, lowers the output strobe for the address-access window and captures the byte at the end of that window. A write selects the device in a setup cycle and then lowers the write strobe for the pulse window. The data drivers turn on only after the strobe has fallen and stay on for one cycle after it rises. The output strobe stays high for the whole write. Completion of either operation is reported with a one-cycle response pulse, which carries the byte on reads.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and immediately after reset the device is deselected (mem_ce_n=1, mem_ce=0), mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, req_ready=1 and rsp_valid=0.
- R2: The device is selected (mem_ce_n=0 together with mem_ce=1) only while an accepted request is in progress, and the two enables always agree on the selection.
- R3: A read holds the device selected with mem_oe_n=0 and mem_we_n=1 for RD_CYC cycles. It captures mem_dq_in at the edge that ends the last of them and presents the byte on rsp_rdata in the following cycle.
- R4: A write keeps mem_oe_n=1 throughout. It has one setup cycle with mem_we_n=1 and then holds mem_we_n=0 for WL_CYC = max(ceil(tWP/T), ceil(tDW/T)+1) cycles, followed by one cycle with mem_we_n=1 before deselection.
- R5: mem_dq_oe is 1 only during a write, from the second low cycle of the write strobe through the cycle after the strobe rises. It is never 1 while mem_oe_n=0 or while the device is deselected.
- R6: mem_addr changes only while the device is deselected; it equals the accepted request's address for the whole access.
- R7: req_ready is 1 exactly when no request is in progress. A request presented while req_ready=0 is ignored: pins, address and data of the ongoing access do not change.
- R8: rsp_valid is a one-cycle pulse in the cycle after each access ends: RD_CYC+1 cycles after a read is accepted and WL_CYC+3 cycles after a write is accepted.
- R9: Phase lengths follow ceil(limit_ns / CLK_PERIOD_NS), minimum one cycle, with SPEED_GRADE=0 using 12 ns access, 9 ns write pulse and 7 ns data setup, and SPEED_GRADE=1 using 15 ns, 10 ns and 8 ns.
- R10: The device is deselected for at least one cycle between any two accesses, including back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid after a read |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Byte seen on the data bus |

## Verification
The properties assume a clean synchronous reset held for at least one edge. They also assume that request fields matter only on the edge where req_valid meets req_ready, so anything the requester does while busy is treated as noise the design must ignore. The stimulus drives requests half a cycle away from the sampling edge. It deliberately holds req_valid high with different fields while an access is running, to show that such input is dropped. The RAM model in the bench drives mem_dq_in only while the device is selected with the output strobe low, so a capture outside the access window returns a wrong byte.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and timing arithmetic for the asynchronous RAM sequencer.
// Assumes limits are whole nanoseconds and the clock period is a whole
// number of nanoseconds greater than zero.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4
    } seq_state_t;

    // Cycles needed to cover a limit, never fewer than one.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    // Address access limit per grade (0 = faster, 1 = slower).
    function automatic int unsigned lim_access_ns(int unsigned grade);
        return (grade == 0) ? 12 : 15;
    endfunction

    // Minimum write strobe width per grade.
    function automatic int unsigned lim_wpulse_ns(int unsigned grade);
        return (grade == 0) ? 9 : 10;
    endfunction

    // Data setup before the strobe rises, per grade.
    function automatic int unsigned lim_dsetup_ns(int unsigned grade);
        return (grade == 0) ? 7 : 8;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures one timing phase.
// Loaded with (length - 1) on entry to a phase; done is high while the
// count is zero, i.e. in the last cycle of the phase.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: walks read and write phases one request at a time.
// Assumes the phase timer reports done in the last cycle of each timed phase.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned RD_LEN = 3,
    parameter int unsigned WL_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic             req_write,
    input  logic             timer_done,
    output seq_state_t       state_q,
    output seq_state_t       state_d,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             rd_capture,
    output logic             complete
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] WL_LOAD = CNT_W'(WL_LEN - 1);

    // Next-state and timer load decisions.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    if (req_write) begin
                        state_d = ST_WSETUP;
                    end else begin
                        state_d    = ST_RD;
                        timer_load = 1'b1;
                        timer_val  = RD_LOAD;
                    end
                end
            end
            ST_RD:     if (timer_done) state_d = ST_IDLE;
            ST_WSETUP: begin
                state_d    = ST_WPULSE;
                timer_load = 1'b1;
                timer_val  = WL_LOAD;
            end
            ST_WPULSE: if (timer_done) state_d = ST_WHOLD;
            ST_WHOLD:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rd_capture = (state_q == ST_RD) && timer_done;
    assign complete   = rd_capture || (state_q == ST_WHOLD);

    // A write setup cycle is always followed by the strobe-low phase.
    assert_setup_then_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WSETUP) |=> (state_q == ST_WPULSE));

    // After the strobe-low phase comes exactly one hold cycle, then idle.
    assert_hold_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WHOLD) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sram_pin_stage.sv
// Registered RAM pin drivers. Every pin comes straight from a flop so the
// strobes cannot glitch. Address and write data are loaded only on request
// acceptance, which happens while the device is deselected.
module sram_pin_stage
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_q,
    input  seq_state_t        state_d,
    input  logic              req_fire,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    // Capture address and write byte when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (req_fire) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Decode the upcoming state into registered control pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= (state_d == ST_IDLE);
            mem_ce    <= (state_d != ST_IDLE);
            mem_we_n  <= (state_d != ST_WPULSE);
            mem_oe_n  <= (state_d != ST_RD);
            mem_dq_oe <= ((state_d == ST_WPULSE) && (state_q == ST_WPULSE))
                         || (state_d == ST_WHOLD);
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous RAM sequencer: request handshake, phase timer,
// sequencer and pin stage. Phase lengths are derived from CLK_PERIOD_NS and
// SPEED_GRADE at elaboration. Assumes the RAM sees every pin change within
// the same clock cycle (board delays well below one period).
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned RD_CYC = ns_to_cycles(lim_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned WP_CYC = ns_to_cycles(lim_wpulse_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned DS_CYC = ns_to_cycles(lim_dsetup_ns(SPEED_GRADE), CLK_PERIOD_NS);
    // Drivers start one cycle into the strobe, so setup needs one extra cycle.
    localparam int unsigned WL_CYC = (WP_CYC > DS_CYC + 1) ? WP_CYC : DS_CYC + 1;
    localparam int unsigned MAX_CYC = (RD_CYC > WL_CYC) ? RD_CYC : WL_CYC;
    localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             req_fire;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             rd_capture;
    logic             complete;
    logic             rsp_valid_q;
    logic [DATA_W-1:0] rdata_q;

    assign req_ready = (state_q == ST_IDLE);
    assign req_fire  = req_valid && req_ready;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_seq_fsm #(.CNT_W(CNT_W), .RD_LEN(RD_CYC), .WL_LEN(WL_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .req_write  (req_write),
        .timer_done (timer_done),
        .state_q    (state_q),
        .state_d    (state_d),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .rd_capture (rd_capture),
        .complete   (complete)
    );

    sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .state_d    (state_d),
        .req_fire   (req_fire),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    // Completion pulse and read byte capture at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= complete;
            if (rd_capture) rdata_q <= mem_dq_in;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rdata_q;

    // The two enables always agree on selection.
    assert_enables_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n == !mem_ce);

    // Address held while selected.
    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // No output strobe during a write strobe.
    assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // Controller drives the bus only when selected and the RAM outputs are off.
    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    // Drivers turn on only after the write strobe has already been low a cycle.
    assert_drive_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(!mem_we_n) && !mem_we_n));

    // Accepting a request drops ready in the next cycle.
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // Completion is a single-cycle pulse.
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // Completion cycle is always a deselected cycle.
    assert_gap_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> mem_ce_n);

endmodule

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/100ps
module sram_async_ctrl_test;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int PERIOD = 5;
    // Expected phase lengths from the faster grade limits (R9).
    localparam int NAA = (12 + PERIOD - 1) / PERIOD;
    localparam int NWP = (9 + PERIOD - 1) / PERIOD;
    localparam int NDS = (7 + PERIOD - 1) / PERIOD;
    localparam int NWL = (NWP > NDS + 1) ? NWP : NDS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.CLK_PERIOD_NS(PERIOD), .SPEED_GRADE(0)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // ---------------- RAM device model ----------------
    logic [DW-1:0] dev_mem [int];
    logic [DW-1:0] dev_pend;
    bit dev_wr_seen = 0;

    function automatic logic [DW-1:0] dev_read(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : 8'h3C;
    endfunction

    // Half a cycle after pins settle: drive read data, latch write on strobe rise.
    always @(negedge clk) begin
        if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) mem_dq_in <= dev_read(int'(mem_addr));
        else mem_dq_in <= 8'h00;
        if (!mem_ce_n && mem_ce && !mem_we_n) begin
            if (mem_dq_oe) dev_pend = mem_dq_out;
            dev_wr_seen = 1;
        end else if (dev_wr_seen) begin
            dev_mem[int'(mem_addr)] = dev_pend;
            dev_wr_seen = 0;
        end
    end

    // ---------------- reference model ----------------
    localparam int OP_NONE = 0, OP_RD = 1, OP_WR = 2;
    int ref_op = OP_NONE;
    int ref_k = 0;
    logic [AW-1:0] ref_addr = '0;
    logic [DW-1:0] ref_data = '0;
    bit ref_rsp = 0;
    bit ref_last_rd = 0;
    logic [DW-1:0] ref_rdata = '0;
    logic [DW-1:0] exp_mem [int];

    always @(posedge clk) begin
        ref_rsp <= 0;
        if (!rst_n) begin
            ref_op <= OP_NONE;
            ref_k  <= 0;
        end else if (ref_op == OP_RD && ref_k == NAA) begin
            ref_op <= OP_NONE;
            ref_rsp <= 1;
            ref_last_rd <= 1;
            ref_rdata <= exp_mem.exists(int'(ref_addr)) ? exp_mem[int'(ref_addr)] : 8'h3C;
        end else if (ref_op == OP_WR && ref_k == NWL + 2) begin
            ref_op <= OP_NONE;
            ref_rsp <= 1;
            ref_last_rd <= 0;
        end else if (ref_op != OP_NONE) begin
            ref_k <= ref_k + 1;
        end else if (req_valid) begin
            ref_op <= req_write ? OP_WR : OP_RD;
            ref_k <= 1;
            ref_addr <= req_addr;
            ref_data <= req_wdata;
            if (req_write) exp_mem[int'(req_addr)] = req_wdata;
        end
    end

    // Compare every output against the reference each cycle.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            bit sel, we_lo, drv;
            sel   = (ref_op != OP_NONE);
            we_lo = (ref_op == OP_WR) && ref_k >= 2 && ref_k <= NWL + 1;
            drv   = (ref_op == OP_WR) && ref_k >= 3 && ref_k <= NWL + 2;
            chk(ref_rsp ? "R10" : "R2", "ce_n", int'(mem_ce_n), int'(!sel));
            chk("R2", "ce", int'(mem_ce), int'(sel));
            chk("R3", "oe_n", int'(mem_oe_n), int'(ref_op != OP_RD));
            chk("R4", "we_n", int'(mem_we_n), int'(!we_lo));
            chk("R5", "dq_oe", int'(mem_dq_oe), int'(drv));
            chk("R7", "ready", int'(req_ready), int'(!sel));
            chk("R8", "rsp_valid", int'(rsp_valid), int'(ref_rsp));
            if (sel) chk("R6", "addr", int'(mem_addr), int'(ref_addr));
            if (drv) chk("R5", "dq_out", int'(mem_dq_out), int'(ref_data));
            if (ref_rsp && ref_last_rd) chk("R3", "rdata", int'(rsp_rdata), int'(ref_rdata));
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    task automatic settle();
        repeat (NWL + 5) @(negedge clk);
    endtask

    // Count edges from acceptance to the completion pulse (R9).
    task automatic measure(input bit wr, input logic [AW-1:0] a, input int exp_lat);
        int lat;
        issue(wr, a, 8'h5A);
        lat = 0;
        @(negedge clk);
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R9", wr ? "write latency" : "read latency", lat, exp_lat);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset ce_n", int'(mem_ce_n), 1);
        chk("R1", "reset ce", int'(mem_ce), 0);
        chk("R1", "reset we_n", int'(mem_we_n), 1);
        chk("R1", "reset oe_n", int'(mem_oe_n), 1);
        chk("R1", "reset dq_oe", int'(mem_dq_oe), 0);
        chk("R1", "reset rsp", int'(rsp_valid), 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1", "ready after reset", int'(req_ready), 1);

        // Writes at boundary addresses and data patterns, then read back.
        issue(1, 17'h00000, 8'h00);
        issue(1, 17'h1FFFF, 8'hFF);
        issue(1, 17'h0A5A5, 8'h96);
        issue(1, 17'h15A5A, 8'h69);
        settle();
        issue(0, 17'h00000, 8'h00);
        issue(0, 17'h1FFFF, 8'h00);
        issue(0, 17'h0A5A5, 8'h00);
        issue(0, 17'h15A5A, 8'h00);
        issue(0, 17'h00123, 8'h00);
        settle();

        // R7: request held while busy with other fields must be ignored.
        issue(0, 17'h1FFFF, 8'h00);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 17'h00777; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 0;
        settle();
        issue(0, 17'h00777, 8'h00);
        settle();

        // Overwrite then read, mixed back-to-back.
        issue(1, 17'h0A5A5, 8'h3B);
        issue(0, 17'h0A5A5, 8'h00);
        issue(1, 17'h00001, 8'hC4);
        issue(0, 17'h00001, 8'h00);
        settle();

        measure(0, 17'h00002, NAA + 1);
        measure(1, 17'h00003, NWL + 3);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            done_flag = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule